// File: doc/BRIEF.md
# Display Status Interrupt Combiner

This block sits beside a display panel controller and turns four kinds of status events into sticky interrupt flags. The four events are a starved transmit FIFO during visible output, a data overflow, the start of a vertical sync pulse, and the completion of a frame. Whether an event counts depends on context. A starved FIFO matters only while pixels are being shown. Overflow is judged one way when the controller fetches data as a bus master and another way when it reads words from the panel. Frame completion follows fields or whole frames, depending on the digital-video mode and an alternate-field option.

Each flag has its own enable bit. The enabled, pending flags are merged into one registered interrupt line. Software reads the flags and the enable bits on output ports. It clears flags by writing ones on a clear port and loads all enable bits at once on a mask port.

Top module: `disp_irq_ctrl`

## Requirements
- R1: While reset is active, and right after it, all four status flags, all four enable bits and the interrupt output are 0.
- R2: Status bit 0 (starvation) sets on the clock edge that ends a cycle where `tx_fifo_empty` and `in_active_area` are both 1. An empty FIFO with `in_active_area` at 0 leaves the bit unchanged.
- R3: With `master_mode` at 1, status bit 1 (overflow) sets on the edge after a cycle with `fetch_overrun` at 1. In that mode `rx_fifo_full` and `rd_word_strobe` do not affect the bit.
- R4: With `master_mode` at 0, status bit 1 sets on the edge after a cycle where `rx_fifo_full` and `rd_word_strobe` are both 1. In that mode `fetch_overrun` does not affect the bit.
- R5: Status bit 2 (sync start) sets once for each leading edge of `vsync_in`. The leading edge is rising when `vsync_lead_high` is 1 and falling when it is 0. Holding the level does not set the bit again after it is cleared.
- R6: With `dvi_mode` at 0, every cycle with `frame_end_pulse` at 1 sets status bit 3 (frame done).
- R7: With `dvi_mode` at 1 and `alt_fields_frame` at 0, every `frame_end_pulse` sets status bit 3. With `alt_fields_frame` at 1, only a pulse that arrives while `second_field` is 1 sets it.
- R8: A status bit stays set until a cycle with `clr_we` at 1 and a 1 in the matching position of `clr_bits`. Positions written with 0 keep their value.
- R9: When a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: A cycle with `mask_we` at 1 loads `mask_bits` into the enable bits, shown on `mask_o` after the edge. Without `mask_we` the enable bits hold.
- R11: `irq_o` equals, one cycle later, the OR over all positions of status AND enable. A pending flag whose enable bit is 0 does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| in_active_area | input | 1 | Controller is in the visible part of the frame |
| rx_fifo_full | input | 1 | Receive FIFO is full |
| rd_word_strobe | input | 1 | A word is being read into the receive FIFO |
| fetch_overrun | input | 1 | Bus master fetched more than the FIFOs can hold |
| master_mode | input | 1 | 1: bus-master fetch mode, 0: panel read mode |
| vsync_in | input | 1 | Vertical sync level |
| vsync_lead_high | input | 1 | 1: rising edge is leading, 0: falling edge is leading |
| frame_end_pulse | input | 1 | One-cycle pulse at the end of a frame or field |
| second_field | input | 1 | The ending field is the second field of a frame |
| dvi_mode | input | 1 | Digital-video interlaced mode select |
| alt_fields_frame | input | 1 | In DVI mode, report whole frames instead of fields |
| clr_we | input | 1 | Write strobe for the clear port |
| clr_bits | input | 4 | Write-one-to-clear pattern |
| mask_we | input | 1 | Write strobe for the enable bits |
| mask_bits | input | 4 | New enable-bit value |
| status_o | output | 4 | Sticky flags: 0 starvation, 1 overflow, 2 sync start, 3 frame done |
| mask_o | output | 4 | Current enable bits |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The context rules are driven on purpose from both sides:
- A starved FIFO inside and outside the visible region, which separates a correct gate from an unconditional one.
- Each overflow cause in the mode that ignores it, which exposes a swapped or missing mode select.
- A held sync level under both polarities, which tells edge detection from level detection.
- Field pulses with the second-field flag at 0 and at 1 under every mode and option pair, which isolates the per-frame reduction.
- A set and a clear of the same flag in one cycle, which shows which one has priority.
- A pending flag with its enable bit off, which proves the mask works and shows the one-cycle interrupt delay.
Several thousand seeded random cycles then mix all inputs and compare every output against a bench model on each cycle.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int unsigned SRC_W = 4;

  typedef enum logic [1:0] {
    SRC_STARVE = 2'd0,
    SRC_OVFL   = 2'd1,
    SRC_VLEAD  = 2'd2,
    SRC_FDONE  = 2'd3
  } src_e;

  // packed: starve lands at bit 0, fdone at bit 3
  typedef struct packed {
    logic fdone;
    logic vlead;
    logic ovfl;
    logic starve;
  } evt_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/irq_event_decode.sv
module irq_event_decode
  import disp_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_fifo_empty,
  input  logic in_active_area,
  input  logic rx_fifo_full,
  input  logic rd_word_strobe,
  input  logic fetch_overrun,
  input  logic master_mode,
  input  logic vsync_in,
  input  logic vsync_lead_high,
  input  logic frame_end_pulse,
  input  logic second_field,
  input  logic dvi_mode,
  input  logic alt_fields_frame,
  output evt_t evt
);
  // Sync level seen as "asserted" under the chosen polarity. Reset value 1
  // means a level already present when reset lifts is not taken as an edge.
  logic lvl_q;
  logic lvl_d;
  logic lvl_cur;
  logic frame_only;

  always_comb begin
    lvl_cur = (vsync_in == vsync_lead_high);
    lvl_d   = lvl_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_d;
  end

  always_comb begin
    frame_only  = dvi_mode & alt_fields_frame;
    evt.starve  = tx_fifo_empty & in_active_area;                     // R2
    evt.ovfl    = master_mode ? fetch_overrun                         // R3
                              : (rx_fifo_full & rd_word_strobe);      // R4
    evt.vlead   = lvl_cur & ~lvl_q;                                   // R5
    evt.fdone   = frame_end_pulse & (~frame_only | second_field);     // R6 R7
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [W-1:0] mask_vec,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] st_q, st_d;
  logic [W-1:0] mk_q, mk_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr_hit;
    always_comb begin
      clr_hit = clr_we & clr_vec[i];
      // set has priority over clear (R9), otherwise sticky (R8)
      st_d[i] = set_vec[i] | (st_q[i] & ~clr_hit);
      mk_d[i] = mask_we ? mask_vec[i] : mk_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= 1'b0;
        mk_q[i] <= 1'b0;
      end else begin
        st_q[i] <= st_d[i];
        mk_q[i] <= mk_d[i];
      end
    end
  end

  assign status_o = st_q;
  assign mask_o   = mk_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = |(status & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_fifo_empty,
  input  logic             in_active_area,
  input  logic             rx_fifo_full,
  input  logic             rd_word_strobe,
  input  logic             fetch_overrun,
  input  logic             master_mode,
  input  logic             vsync_in,
  input  logic             vsync_lead_high,
  input  logic             frame_end_pulse,
  input  logic             second_field,
  input  logic             dvi_mode,
  input  logic             alt_fields_frame,
  input  logic             clr_we,
  input  logic [SRC_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [SRC_W-1:0] mask_bits,
  output logic [SRC_W-1:0] status_o,
  output logic [SRC_W-1:0] mask_o,
  output logic             irq_o
);
  logic rst_q_n;
  evt_t evt;
  logic [SRC_W-1:0] st;
  logic [SRC_W-1:0] mk;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  irq_event_decode u_dec (
    .clk              (clk),
    .rst_n            (rst_q_n),
    .tx_fifo_empty    (tx_fifo_empty),
    .in_active_area   (in_active_area),
    .rx_fifo_full     (rx_fifo_full),
    .rd_word_strobe   (rd_word_strobe),
    .fetch_overrun    (fetch_overrun),
    .master_mode      (master_mode),
    .vsync_in         (vsync_in),
    .vsync_lead_high  (vsync_lead_high),
    .frame_end_pulse  (frame_end_pulse),
    .second_field     (second_field),
    .dvi_mode         (dvi_mode),
    .alt_fields_frame (alt_fields_frame),
    .evt              (evt)
  );

  irq_flag_bank #(.W(SRC_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .set_vec  (evt),
    .clr_we   (clr_we),
    .clr_vec  (clr_bits),
    .mask_we  (mask_we),
    .mask_vec (mask_bits),
    .status_o (st),
    .mask_o   (mk)
  );

  irq_merge #(.W(SRC_W)) u_merge (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .status (st),
    .mask   (mk),
    .irq_o  (irq_o)
  );

  assign status_o = st;
  assign mask_o   = mk;
endmodule

// File: rtl/disp_irq_ctrl_chk.sv
module disp_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       tx_fifo_empty,
  input logic       in_active_area,
  input logic       rx_fifo_full,
  input logic       rd_word_strobe,
  input logic       fetch_overrun,
  input logic       master_mode,
  input logic       vsync_in,
  input logic       vsync_lead_high,
  input logic       clr_we,
  input logic [3:0] clr_bits,
  input logic       mask_we,
  input logic [3:0] mask_bits,
  input logic [3:0] status_o,
  input logic [3:0] mask_o,
  input logic       irq_o
);
  logic [3:0] keep;
  assign keep = status_o & ~(clr_we ? clr_bits : 4'b0000);

  assert_starve_set_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (tx_fifo_empty && in_active_area) |=> status_o[0]);

  assert_starve_quiet_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (!status_o[0] && !(tx_fifo_empty && in_active_area)) |=> !status_o[0]);

  assert_master_ovfl_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (master_mode && fetch_overrun) |=> status_o[1]);

  assert_read_ovfl_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (!master_mode && rx_fifo_full && rd_word_strobe) |=> status_o[1]);

  assert_rise_lead_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && vsync_lead_high && $past(vsync_lead_high)
     && vsync_in && !$past(vsync_in)) |=> status_o[2]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (|keep) |=> ((status_o & $past(keep)) == $past(keep)));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (clr_we && clr_bits[0] && tx_fifo_empty && in_active_area) |=> status_o[0]);

  assert_mask_load_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    mask_we |=> (mask_o == $past(mask_bits)));

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !mask_we |=> $stable(mask_o));

  assert_irq_merge_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_ok |=> (irq_o == |($past(status_o & mask_o))));

  always_comb begin
    if (!rst_ok) begin
      assert_reset_clear_R1: assert (status_o == 4'b0000 && mask_o == 4'b0000 && !irq_o);
    end
  end
endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk u_chk (
  .clk             (clk),
  .rst_ok          (rst_q_n),
  .tx_fifo_empty   (tx_fifo_empty),
  .in_active_area  (in_active_area),
  .rx_fifo_full    (rx_fifo_full),
  .rd_word_strobe  (rd_word_strobe),
  .fetch_overrun   (fetch_overrun),
  .master_mode     (master_mode),
  .vsync_in        (vsync_in),
  .vsync_lead_high (vsync_lead_high),
  .clr_we          (clr_we),
  .clr_bits        (clr_bits),
  .mask_we         (mask_we),
  .mask_bits       (mask_bits),
  .status_o        (status_o),
  .mask_o          (mask_o),
  .irq_o           (irq_o)
);

// File: tb/disp_irq_ctrl_tb_top.sv
module disp_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic tx_fifo_empty, in_active_area, rx_fifo_full, rd_word_strobe;
  logic fetch_overrun, master_mode, vsync_in, vsync_lead_high;
  logic frame_end_pulse, second_field, dvi_mode, alt_fields_frame;
  logic clr_we, mask_we;
  logic [3:0] clr_bits, mask_bits;
  logic [3:0] status_o, mask_o;
  logic irq_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [3:0] m_st, m_mk;
  logic m_irq, m_lvl;

  always #10 clk = ~clk;

  disp_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_fifo_empty(tx_fifo_empty), .in_active_area(in_active_area),
    .rx_fifo_full(rx_fifo_full), .rd_word_strobe(rd_word_strobe),
    .fetch_overrun(fetch_overrun), .master_mode(master_mode),
    .vsync_in(vsync_in), .vsync_lead_high(vsync_lead_high),
    .frame_end_pulse(frame_end_pulse), .second_field(second_field),
    .dvi_mode(dvi_mode), .alt_fields_frame(alt_fields_frame),
    .clr_we(clr_we), .clr_bits(clr_bits), .mask_we(mask_we), .mask_bits(mask_bits),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_events(logic lead);
    logic [3:0] e;
    e[0] = tx_fifo_empty & in_active_area;
    e[1] = master_mode ? fetch_overrun : (rx_fifo_full & rd_word_strobe);
    e[2] = lead;
    e[3] = frame_end_pulse & (!(dvi_mode & alt_fields_frame) | second_field);
    return e;
  endfunction

  function automatic string bit_tag(int k);
    case (k)
      0: return "R2";
      1: return master_mode ? "R3" : "R4";
      2: return "R5";
      default: return dvi_mode ? "R7" : "R6";
    endcase
  endfunction

  task automatic idle();
    tx_fifo_empty = 0; in_active_area = 0; rx_fifo_full = 0; rd_word_strobe = 0;
    fetch_overrun = 0; frame_end_pulse = 0; second_field = 0;
    clr_we = 0; clr_bits = 0; mask_we = 0; mask_bits = 0;
  endtask

  // one clock: model follows the inputs present at the edge, compare at negedge
  task automatic tick();
    logic cur;
    logic [3:0] ev, cv;
    @(posedge clk);
    if (!rst_n) begin
      m_st = 0; m_mk = 0; m_irq = 0; m_lvl = 1;
    end else begin
      m_irq = |(m_st & m_mk);
      cur = (vsync_in == vsync_lead_high);
      ev = exp_events(cur & ~m_lvl);
      m_lvl = cur;
      cv = clr_we ? clr_bits : 4'b0;
      m_st = (m_st & ~cv) | ev;
      if (mask_we) m_mk = mask_bits;
    end
    @(negedge clk);
    for (int k = 0; k < 4; k++) chk(bit_tag(k), {3'b0, status_o[k]}, {3'b0, m_st[k]});
    chk("R10", mask_o, m_mk);
    chk("R11", {3'b0, irq_o}, {3'b0, m_irq});
  endtask

  task automatic clear_all();
    idle(); clr_we = 1; clr_bits = 4'hF; tick(); idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 5107;
    void'($urandom(seed));
    rst_n = 0; idle();
    master_mode = 1; vsync_in = 0; vsync_lead_high = 1; dvi_mode = 0; alt_fields_frame = 0;
    tick(); tick();
    chk("R1", status_o, 4'h0); chk("R1", mask_o, 4'h0); chk("R1", {3'b0, irq_o}, 4'h0);
    rst_n = 1;
    repeat (4) tick();
    chk("R1", status_o, 4'h0);

    // R2 gating by visible region
    tx_fifo_empty = 1; in_active_area = 0; tick();
    chk("R2", {3'b0, status_o[0]}, 4'h0);
    in_active_area = 1; tick();
    chk("R2", {3'b0, status_o[0]}, 4'h1);
    idle(); frame_end_pulse = 1; tick(); idle();
    // R8 partial clear
    clr_we = 1; clr_bits = 4'b0001; tick(); idle();
    chk("R8", status_o, 4'b1000);
    // R9 set beats clear
    tx_fifo_empty = 1; in_active_area = 1; clr_we = 1; clr_bits = 4'b0001; tick();
    chk("R9", {3'b0, status_o[0]}, 4'h1);
    clear_all();
    chk("R8", status_o, 4'h0);

    // R3 master mode
    master_mode = 1; rx_fifo_full = 1; rd_word_strobe = 1; tick();
    chk("R3", {3'b0, status_o[1]}, 4'h0);
    idle(); fetch_overrun = 1; tick();
    chk("R3", {3'b0, status_o[1]}, 4'h1);
    clear_all();
    // R4 read mode
    master_mode = 0; fetch_overrun = 1; tick();
    chk("R4", {3'b0, status_o[1]}, 4'h0);
    idle(); rx_fifo_full = 1; tick();
    chk("R4", {3'b0, status_o[1]}, 4'h0);
    rd_word_strobe = 1; tick();
    chk("R4", {3'b0, status_o[1]}, 4'h1);
    clear_all();

    // R5 polarity and held level
    vsync_lead_high = 1; vsync_in = 1; tick();
    chk("R5", {3'b0, status_o[2]}, 4'h1);
    clear_all(); tick();
    chk("R5", {3'b0, status_o[2]}, 4'h0);
    vsync_lead_high = 0; tick();
    chk("R5", {3'b0, status_o[2]}, 4'h0);
    vsync_in = 0; tick();
    chk("R5", {3'b0, status_o[2]}, 4'h1);
    clear_all(); vsync_lead_high = 1; tick();

    // R6 and R7 frame completion
    dvi_mode = 0; frame_end_pulse = 1; tick(); idle();
    chk("R6", {3'b0, status_o[3]}, 4'h1);
    clear_all();
    dvi_mode = 1; alt_fields_frame = 1; frame_end_pulse = 1; second_field = 0; tick();
    chk("R7", {3'b0, status_o[3]}, 4'h0);
    second_field = 1; tick(); idle();
    chk("R7", {3'b0, status_o[3]}, 4'h1);
    clear_all();
    alt_fields_frame = 0; frame_end_pulse = 1; second_field = 0; tick(); idle();
    chk("R7", {3'b0, status_o[3]}, 4'h1);
    clear_all(); dvi_mode = 0;

    // R10 and R11 masking and delay
    mask_we = 1; mask_bits = 4'b0100; tick(); idle();
    chk("R10", mask_o, 4'b0100);
    vsync_in = 1; tick();
    chk("R11", {3'b0, irq_o}, 4'h0);
    tick();
    chk("R11", {3'b0, irq_o}, 4'h1);
    mask_we = 1; mask_bits = 4'b1011; tick(); idle(); tick();
    chk("R11", {3'b0, irq_o}, 4'h0);
    chk("R8", {3'b0, status_o[2]}, 4'h1);
    clear_all(); vsync_in = 0; tick();

    // seeded random mix
    for (int n = 0; n < 4000; n++) begin
      tx_fifo_empty   = ($urandom % 4) == 0;
      in_active_area  = $urandom % 2;
      rx_fifo_full    = ($urandom % 3) == 0;
      rd_word_strobe  = $urandom % 2;
      fetch_overrun   = ($urandom % 6) == 0;
      if (($urandom % 50) == 0) master_mode = ~master_mode;
      if (($urandom % 5) == 0) vsync_in = ~vsync_in;
      if (($urandom % 200) == 0) vsync_lead_high = ~vsync_lead_high;
      frame_end_pulse = ($urandom % 8) == 0;
      second_field    = $urandom % 2;
      if (($urandom % 100) == 0) dvi_mode = ~dvi_mode;
      if (($urandom % 100) == 0) alt_fields_frame = ~alt_fields_frame;
      clr_we   = ($urandom % 3) == 0;
      clr_bits = 4'($urandom);
      mask_we  = ($urandom % 20) == 0;
      mask_bits = 4'($urandom);
      tick();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule